// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Model

This block acts as the memory chip on the far side of a DRAM controller under test. The controller drives row and column strobes (active low), a write strobe, an output enable and a shared address bus. The model answers on a bidirectional 4-bit data bus in the way an asynchronous page-mode DRAM does. The storage is a small parameterised array. Row and column fields are taken from the low address bits, so a controller written for a much larger part can run against it unchanged.

All strobes are sampled on a free-running simulation clock, and edges are found by comparing each sample with the one before. The row is captured when the row strobe falls. The column latch follows the bus while the column strobe is high and freezes when it falls. Write data is taken on whichever strobe falls later: the column strobe for an early write, the write strobe for a delayed write or read-modify-write. Read data and the bus drive are registered, so they appear one sample after the strobes that cause them.

Top module: `adram_emu`

## Requirements
- R1: Once reset is released, the model leaves the data bus undriven (`dq_en` low).
- R2: The row field (`addr[ROW_BITS-1:0]`) is captured in the first sample in which `ras_n` is low after being high. Later address changes do not alter the row until `ras_n` has gone high and fallen again.
- R3: While `cas_n` is high, the column field (`addr[COL_BITS-1:0]`) follows the bus. The value present in the sample where `cas_n` falls is kept until `cas_n` rises, and address changes during that low phase are ignored.
- R4: Early write. If `we_n` is low in the sample where `cas_n` falls, the value on `dq` is stored at that sample. The bus stays undriven for the whole column cycle, even with `oe_n` low.
- R5: Delayed write. If `we_n` falls while `cas_n` is already low and the cycle began as a read, the value on `dq` is stored at the sample where `we_n` falls.
- R6: Read-modify-write. Within one column cycle, the stored word is first driven out. After `oe_n` rises and `we_n` falls, the new word replaces it at the same location.
- R7: `dq_en` is high, and `dq` carries the addressed word, only in the sample after `ras_n`, `cas_n` and `oe_n` are all low with `we_n` high in a read cycle. In every other case the bus is released.
- R8: Page mode. With `ras_n` held low, each new falling edge of `cas_n` accesses a new column in the row already latched.
- R9: Address bits above the row and column fields are ignored, so addresses that differ only in those bits alias to the same word.
- R10: In the sample after `ras_n` is high, the bus is released. A `cas_n`/`we_n` cycle while `ras_n` is high stores nothing.
- R11: Data is read back with the same polarity it was written with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, low selects write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq | inout | DQ_W | Bidirectional data bus |
| dq_en | output | 1 | High while the model drives `dq` |

## Verification
The hardest case to reach is the bus turnaround inside a single column cycle. In a read-modify-write, the model must drive the old word and then release the bus. Only after that may the bench drive the new word, and `we_n` must fall while `cas_n` stays low. The stimulus holds `cas_n` low across several samples and changes one control at a time: first `oe_n` low to read, then `oe_n` high, then bench data onto the bus, then `we_n` low. It then reads the location back in a fresh row cycle. A contention assertion watches for any overlap between the model's drive and the bench's drive during this sequence.

// File: rtl/adram_emu.sv
module adram_emu #(
  parameter int DQ_W     = 4,
  parameter int ADDR_W   = 12,
  parameter int ROW_BITS = 4,
  parameter int COL_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DQ_W-1:0]   dq,
  output logic              dq_en
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic ras_q, cas_q, we_q;
  logic row_open, cyc_act, early_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q, col_now;
  logic [DQ_W-1:0]     dout_q;
  logic [DQ_W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0]    idx;
  logic row_open_nx, cyc_nx, early_nx, drv_nx, wr;
  logic unused_addr_bits;

  wire ras_fall = ras_q & ~ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire we_fall  = we_q  & ~we_n;

  assign unused_addr_bits = ^addr;
  assign col_now = cas_q ? addr[COL_BITS-1:0] : col_q;
  assign idx     = {row_q, col_now};

  assign row_open_nx = ~ras_n & (ras_fall | row_open);
  assign cyc_nx      = ~ras_n & ~cas_n & row_open & (cas_fall | cyc_act);
  assign early_nx    = cyc_nx & (cas_fall ? ~we_n : early_q);
  assign drv_nx      = cyc_nx & ~oe_n & we_n & ~early_nx;
  assign wr = (cas_fall & row_open & ~ras_n & ~we_n)
            | (we_fall & cyc_act & ~cas_n & ~ras_n & ~early_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      we_q     <= 1'b1;
      row_open <= 1'b0;
      cyc_act  <= 1'b0;
      early_q  <= 1'b0;
      dq_en    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      dout_q   <= '0;
    end else begin
      ras_q    <= ras_n;
      cas_q    <= cas_n;
      we_q     <= we_n;
      row_open <= row_open_nx;
      cyc_act  <= cyc_nx;
      early_q  <= early_nx;
      dq_en    <= drv_nx;
      dout_q   <= mem[idx];
      if (ras_fall) row_q <= addr[ROW_BITS-1:0];
      if (cas_q)    col_q <= addr[COL_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= dq;
  end

  assign dq = dq_en ? dout_q : 'z;

  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && row_open) |=> $stable(row_q));

  // R3
  col_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_act && !cas_n) |=> $stable(col_q));

  // R4
  early_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fall && row_open && !ras_n && !we_n) |=> !dq_en);

  // R10
  ras_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |=> !dq_en);

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> (dq == dout_q));
endmodule

// File: tb/test_adram_emu.sv
`timescale 1ns/1ps
module test_adram_emu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic tb_oe = 1'b0;
  logic [3:0] tb_d = '0;
  wire  [3:0] dq;
  logic dq_en;
  int cyc = 0, n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { int due; int req; logic en; logic [3:0] d; } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign dq = tb_oe ? tb_d : 'z;

  adram_emu i_adram_emu (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq(dq), .dq_en(dq_en));

  task automatic drv(input logic r, input logic c, input logic w, input logic o,
                     input logic [11:0] a, input logic te, input logic [3:0] td);
    @(posedge clk); #1;
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; tb_oe = te; tb_d = td;
  endtask

  task automatic exp(input int r, input logic en, input logic [3:0] d);
    sb.push_back('{cyc + 1, r, en, d});
  endtask

  task automatic idle();
    drv(1, 1, 1, 1, 12'h0, 0, 4'h0);
  endtask

  // R4: early write with oe_n low, bus must stay released
  task automatic early_wr(input logic [11:0] row, input logic [11:0] col, input logic [3:0] d);
    idle();
    drv(0, 1, 1, 1, row, 0, 4'h0);
    drv(0, 1, 0, 0, col, 1, d);
    drv(0, 0, 0, 0, col, 1, d); exp(4, 0, 4'h0);
    drv(0, 0, 0, 0, col, 1, d); exp(4, 0, 4'h0);
    drv(0, 1, 1, 1, col, 0, 4'h0);
    idle();
  endtask

  // R7: read cycle drives, cas high releases
  task automatic rd(input logic [11:0] row, input logic [11:0] col, input logic [3:0] d, input int r);
    idle();
    drv(0, 1, 1, 1, row, 0, 4'h0);
    drv(0, 1, 1, 1, col, 0, 4'h0);
    drv(0, 0, 1, 0, col, 0, 4'h0); exp(r, 1, d);
    drv(0, 1, 1, 1, col, 0, 4'h0); exp(7, 0, 4'h0);
    idle();
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        it = sb.pop_front();
        n_tests++;
        if (dq_en !== it.en || (it.en && dq !== it.d)) begin
          n_fail++;
          $display("FAIL R%0d: dq_en=%b dq=%h expected dq_en=%b dq=%h",
                   it.req, dq_en, dq, it.en, it.d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: expired expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(); exp(1, 0, 4'h0);            // R1

    early_wr(12'h006, 12'h006, 4'h9);
    early_wr(12'h003, 12'h005, 4'hA);
    early_wr(12'h003, 12'h006, 4'h5);
    early_wr(12'h007, 12'h005, 4'hC);

    rd(12'h003, 12'h005, 4'hA, 11);     // R11 polarity
    rd(12'h007, 12'h005, 4'hC, 7);

    // R3: transparency while cas high, then freeze while low
    idle();
    drv(0, 1, 1, 1, 12'h003, 0, 4'h0);
    drv(0, 1, 1, 1, 12'h000, 0, 4'h0);
    drv(0, 1, 1, 1, 12'h005, 0, 4'h0);
    drv(0, 0, 1, 0, 12'h005, 0, 4'h0); exp(3, 1, 4'hA);
    drv(0, 0, 1, 0, 12'h006, 0, 4'h0);
    drv(0, 0, 1, 0, 12'h006, 0, 4'h0); exp(3, 1, 4'hA);
    idle(); exp(10, 0, 4'h0);           // R10

    // R8 / R2: page mode in row 3, addr later equals 6 but row stays
    drv(0, 1, 1, 1, 12'h003, 0, 4'h0);
    drv(0, 1, 1, 1, 12'h005, 0, 4'h0);
    drv(0, 0, 1, 0, 12'h005, 0, 4'h0); exp(8, 1, 4'hA);
    drv(0, 1, 1, 1, 12'h006, 0, 4'h0);
    drv(0, 0, 1, 0, 12'h006, 0, 4'h0); exp(2, 1, 4'h5);
    drv(0, 1, 1, 1, 12'h006, 0, 4'h0);
    idle();

    // R5: delayed write into row 7 col 5
    drv(0, 1, 1, 1, 12'h007, 0, 4'h0);
    drv(0, 1, 1, 1, 12'h005, 0, 4'h0);
    drv(0, 0, 1, 1, 12'h005, 0, 4'h0); exp(7, 0, 4'h0);
    drv(0, 0, 1, 1, 12'h005, 1, 4'h3);
    drv(0, 0, 0, 1, 12'h005, 1, 4'h3);
    drv(0, 1, 1, 1, 12'h005, 0, 4'h0);
    idle();
    rd(12'h007, 12'h005, 4'h3, 5);

    // R6: read-modify-write at row 3 col 6
    drv(0, 1, 1, 1, 12'h003, 0, 4'h0);
    drv(0, 1, 1, 1, 12'h006, 0, 4'h0);
    drv(0, 0, 1, 0, 12'h006, 0, 4'h0); exp(6, 1, 4'h5);
    drv(0, 0, 1, 1, 12'h006, 0, 4'h0); exp(6, 0, 4'h0);
    drv(0, 0, 1, 1, 12'h006, 1, 4'hE);
    drv(0, 0, 0, 1, 12'h006, 1, 4'hE);
    drv(0, 1, 1, 1, 12'h006, 0, 4'h0);
    idle();
    rd(12'h003, 12'h006, 4'hE, 6);

    // R9: upper address bits ignored
    early_wr(12'hAB2, 12'hCD9, 4'h7);
    rd(12'h002, 12'h009, 4'h7, 9);
    rd(12'hF03, 12'h3A5, 4'hA, 9);

    // R10: strobes with ras high store nothing
    drv(1, 1, 1, 1, 12'h005, 0, 4'h0);
    drv(1, 0, 0, 0, 12'h005, 1, 4'h1); exp(10, 0, 4'h0);
    drv(1, 0, 0, 0, 12'h005, 1, 4'h1); exp(10, 0, 4'h0);
    drv(1, 1, 1, 1, 12'h005, 0, 4'h0);
    rd(12'h003, 12'h005, 4'hA, 10);

    idle(); idle(); idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule